// File: doc/BRIEF.md
# Pulse-Swallow Frequency Divider Chain

This block is the digital division chain of an integer-N frequency synthesizer. Two counters run in their own clock domains. The reference counter divides the reference clock by a programmable ratio and emits a comparison pulse `fr`. The feedback path divides the oscillator-side clock through a modelled dual-modulus prescaler, and a swallow/main counter pair steers it. Each feedback period emits one pulse `fp`. A phase detector downstream compares the two pulses.

The prescaler runs cycles of P or P+1 oscillator clocks, where P is 32 or 64 according to a select bit. Each feedback period holds N prescaler cycles. During the first A of them the modulus-control output asks for P+1. The feedback ratio is therefore N·P + A. All settings are sampled only at a period boundary, so a change never produces a shortened or stretched period.

The reference counter is built from the states REF_IDLE and REF_COUNT. It moves from REF_IDLE to REF_COUNT on the first clock after reset and then stays in REF_COUNT, reloading on each wrap. The prescaler is built from PRE_IDLE and PRE_RUN. It leaves PRE_IDLE when the controller issues its first load and then restarts on every cycle end. The feedback controller has three states: FB_IDLE, FB_SWALLOW and FB_MAIN. It leaves FB_IDLE with a load. From there it enters FB_SWALLOW when the swallow count is non-zero and FB_MAIN otherwise. It moves from FB_SWALLOW to FB_MAIN when the swallow count is used up. At the end of a period it returns to FB_SWALLOW or FB_MAIN by reloading.

Top module: `dc_divider_chain`

## Requirements
- R1: With a reference ratio R of 8 or more, `fr` is high for exactly one `ref_clk` cycle in every R cycles. The first pulse comes in the R-th cycle after the first rising edge that sees reset released.
- R2: A reference ratio below 8 is divided as 8.
- R3: `fp` is high for exactly one `vco_clk` cycle per feedback period of N·P + A cycles. The first period begins at the first rising edge that sees reset released.
- R4: `mod_hi` is high for the first A·(P+1) cycles of each feedback period and low for the rest of it.
- R5: `pre_small` = 1 selects P = 32 (32/33), and `pre_small` = 0 selects P = 64 (64/65).
- R6: A change of any setting during a period takes effect only from the next period of the affected counter.
- R7: When the swallow count exceeds the effective main count, `cfg_err` is high for the whole period that setting governs. The swallow count is then taken as equal to the main count.
- R8: A main count of 0 is treated as 1.
- R9: While its reset is low, each domain holds its outputs (`fr`, or `fp`, `mod_hi` and `cfg_err`) low. Those outputs stay low in the first cycle after the reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| ref_rst_n | input | 1 | Asynchronous active-low reset, reference domain |
| ref_ratio | input | 14 | Reference divide ratio R |
| vco_clk | input | 1 | Oscillator-side clock feeding the prescaler |
| vco_rst_n | input | 1 | Asynchronous active-low reset, feedback domain |
| pre_small | input | 1 | Prescaler select: 1 = 32/33, 0 = 64/65 |
| swallow_cnt | input | 7 | Swallow count A |
| main_cnt | input | 11 | Main count N |
| fr | output | 1 | Reference comparison pulse |
| fp | output | 1 | Feedback comparison pulse |
| mod_hi | output | 1 | Modulus control: 1 asks the prescaler for P+1 |
| cfg_err | output | 1 | Swallow count larger than main count in the active period |

## Verification
The bench builds the block with its default widths (14-bit reference ratio, 7-bit swallow count, 11-bit main count) and with the 32 and 64 moduli. Small N and A values keep each feedback period to a few dozen to a few hundred clocks. This lets the bench pass many period boundaries and mid-period setting changes. Those settings cover both moduli, A = 0, A = N, A > N, N = 0 and a reference ratio below the floor, and each is compared cycle by cycle against a counting model.

// File: rtl/dc_pkg.sv
package dc_pkg;

    typedef enum logic [0:0] {
        REF_IDLE  = 1'b0,
        REF_COUNT = 1'b1
    } ref_state_e;

    typedef enum logic [0:0] {
        PRE_IDLE = 1'b0,
        PRE_RUN  = 1'b1
    } pre_state_e;

    typedef enum logic [1:0] {
        FB_IDLE    = 2'd0,
        FB_SWALLOW = 2'd1,
        FB_MAIN    = 2'd2
    } fb_state_e;

endpackage

// File: rtl/dc_ref_div.sv
module dc_ref_div
    import dc_pkg::*;
#(
    parameter int RW    = 14,
    parameter int R_MIN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ratio_in,
    output logic          fr_o
);

    localparam logic [RW-1:0] FLOOR = RW'(R_MIN);
    localparam logic [RW-1:0] ONE   = RW'(1);

    ref_state_e    state_q, state_d;
    logic [RW-1:0] cnt_q, cnt_d;
    logic [RW-1:0] eff_ratio;
    logic          wrap;

    // ratios below the floor are divided as the floor (R2)
    always_comb eff_ratio = (ratio_in < FLOOR) ? FLOOR : ratio_in;

    always_comb wrap = (state_q == REF_COUNT) && (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            REF_IDLE: begin
                state_d = REF_COUNT;
                cnt_d   = eff_ratio - ONE;
            end
            REF_COUNT: begin
                // new ratio only sampled on wrap (R6)
                cnt_d = wrap ? (eff_ratio - ONE) : (cnt_q - ONE);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REF_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    always_comb fr_o = wrap;

endmodule

// File: rtl/dc_prescaler.sv
module dc_prescaler
    import dc_pkg::*;
#(
    parameter int P_SMALL = 32,
    parameter int P_LARGE = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic mod_next_i,
    input  logic small_next_i,
    output logic pre_end_o
);

    localparam int             CW     = $clog2(P_LARGE + 2);
    localparam logic [CW-1:0]  BASE_S = CW'(P_SMALL - 1);
    localparam logic [CW-1:0]  BASE_L = CW'(P_LARGE - 1);
    localparam logic [CW-1:0]  ONE    = CW'(1);

    pre_state_e    state_q, state_d;
    logic [CW-1:0] pcnt_q, pcnt_d;
    logic [CW-1:0] reload;
    logic          cyc_end;

    // cycle length P or P+1, taken from the level seen at cycle start
    always_comb reload = (small_next_i ? BASE_S : BASE_L) + CW'(mod_next_i);

    always_comb cyc_end = (state_q == PRE_RUN) && (pcnt_q == '0);

    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q;
        unique case (state_q)
            PRE_IDLE: begin
                if (start_i) begin
                    state_d = PRE_RUN;
                    pcnt_d  = reload;
                end
            end
            PRE_RUN: begin
                pcnt_d = cyc_end ? reload : (pcnt_q - ONE);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PRE_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    always_comb pre_end_o = cyc_end;

endmodule

// File: rtl/dc_swallow_ctrl.sv
module dc_swallow_ctrl
    import dc_pkg::*;
#(
    parameter int AW = 7,
    parameter int NW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] swallow_in,
    input  logic [NW-1:0] main_in,
    input  logic          small_in,
    input  logic          pre_end_i,
    output logic          load_o,
    output logic          mod_next_o,
    output logic          small_next_o,
    output logic          mod_hi_o,
    output logic          fp_o,
    output logic          cfg_err_o
);

    localparam logic [NW-1:0] ONE = NW'(1);

    fb_state_e     state_q, state_d;
    logic [NW-1:0] a_rem_q, a_rem_d;
    logic [NW-1:0] n_rem_q, n_rem_d;
    logic          small_q, small_d;
    logic          err_q, err_d;

    logic [NW-1:0] a_ext, n_eff, a_eff, a_dec;
    logic          a_over, last_cyc, load;

    always_comb begin
        a_ext    = NW'(swallow_in);
        n_eff    = (main_in == '0) ? ONE : main_in;     // R8
        a_over   = (a_ext > n_eff);                      // R7
        a_eff    = a_over ? n_eff : a_ext;
        a_dec    = (a_rem_q != '0) ? (a_rem_q - ONE) : a_rem_q;
        last_cyc = pre_end_i && (n_rem_q == ONE);
        load     = (state_q == FB_IDLE) || last_cyc;
    end

    always_comb begin
        state_d = state_q;
        a_rem_d = a_rem_q;
        n_rem_d = n_rem_q;
        small_d = small_q;
        err_d   = err_q;
        if (load) begin
            a_rem_d = a_eff;
            n_rem_d = n_eff;
            small_d = small_in;
            err_d   = a_over;
            state_d = (a_eff != '0) ? FB_SWALLOW : FB_MAIN;
        end else begin
            unique case (state_q)
                FB_IDLE: state_d = FB_IDLE;
                FB_SWALLOW: begin
                    if (pre_end_i) begin
                        a_rem_d = a_dec;
                        n_rem_d = n_rem_q - ONE;
                        state_d = (a_dec != '0) ? FB_SWALLOW : FB_MAIN;
                    end
                end
                FB_MAIN: begin
                    if (pre_end_i) n_rem_d = n_rem_q - ONE;
                end
                default: state_d = FB_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FB_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_rem_q <= '0;
            n_rem_q <= '0;
            small_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            a_rem_q <= a_rem_d;
            n_rem_q <= n_rem_d;
            small_q <= small_d;
            err_q   <= err_d;
        end
    end

    // outputs: prescaler steering follows the state being entered
    always_comb begin
        load_o       = load;
        mod_next_o   = (state_d == FB_SWALLOW);
        small_next_o = small_d;
        mod_hi_o     = (state_q == FB_SWALLOW);
        fp_o         = last_cyc;
        cfg_err_o    = err_q;
    end

endmodule

// File: rtl/dc_divider_chain.sv
module dc_divider_chain
    import dc_pkg::*;
#(
    parameter int RW      = 14,
    parameter int R_MIN   = 8,
    parameter int AW      = 7,
    parameter int NW      = 11,
    parameter int P_SMALL = 32,
    parameter int P_LARGE = 64
) (
    input  logic          ref_clk,
    input  logic          ref_rst_n,
    input  logic [RW-1:0] ref_ratio,
    input  logic          vco_clk,
    input  logic          vco_rst_n,
    input  logic          pre_small,
    input  logic [AW-1:0] swallow_cnt,
    input  logic [NW-1:0] main_cnt,
    output logic          fr,
    output logic          fp,
    output logic          mod_hi,
    output logic          cfg_err
);

    logic pre_end_w;
    logic load_w;
    logic mod_next_w;
    logic small_next_w;

    dc_ref_div #(
        .RW    (RW),
        .R_MIN (R_MIN)
    ) u_ref (
        .clk      (ref_clk),
        .rst_n    (ref_rst_n),
        .ratio_in (ref_ratio),
        .fr_o     (fr)
    );

    dc_prescaler #(
        .P_SMALL (P_SMALL),
        .P_LARGE (P_LARGE)
    ) u_pre (
        .clk          (vco_clk),
        .rst_n        (vco_rst_n),
        .start_i      (load_w),
        .mod_next_i   (mod_next_w),
        .small_next_i (small_next_w),
        .pre_end_o    (pre_end_w)
    );

    dc_swallow_ctrl #(
        .AW (AW),
        .NW (NW)
    ) u_ctrl (
        .clk          (vco_clk),
        .rst_n        (vco_rst_n),
        .swallow_in   (swallow_cnt),
        .main_in      (main_cnt),
        .small_in     (pre_small),
        .pre_end_i    (pre_end_w),
        .load_o       (load_w),
        .mod_next_o   (mod_next_w),
        .small_next_o (small_next_w),
        .mod_hi_o     (mod_hi),
        .fp_o         (fp),
        .cfg_err_o    (cfg_err)
    );

endmodule

// File: rtl/dc_divider_chain_chk.sv
module dc_divider_chain_chk (
    input logic ref_clk,
    input logic ref_rst_n,
    input logic vco_clk,
    input logic vco_rst_n,
    input logic fr,
    input logic fp,
    input logic mod_hi,
    input logic cfg_err,
    input logic pre_end_w,
    input logic load_w
);

    assert_fr_single_R1: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        fr |=> !fr);

    assert_fp_single_R3: assert property (@(posedge vco_clk) disable iff (!vco_rst_n)
        fp |=> !fp);

    assert_fp_on_cycle_end_R3: assert property (@(posedge vco_clk) disable iff (!vco_rst_n)
        fp |-> pre_end_w);

    assert_mod_moves_at_cycle_end_R4: assert property (@(posedge vco_clk) disable iff (!vco_rst_n)
        !$stable(mod_hi) |-> $past(pre_end_w || load_w));

    assert_err_moves_at_load_R7: assert property (@(posedge vco_clk) disable iff (!vco_rst_n)
        !$stable(cfg_err) |-> $past(load_w));

endmodule

bind dc_divider_chain dc_divider_chain_chk u_chk (
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .vco_clk   (vco_clk),
    .vco_rst_n (vco_rst_n),
    .fr        (fr),
    .fp        (fp),
    .mod_hi    (mod_hi),
    .cfg_err   (cfg_err),
    .pre_end_w (pre_end_w),
    .load_w    (load_w)
);

// File: tb/tb_dc_divider_chain.sv
module tb_dc_divider_chain;

    localparam int VCO_PERIOD = 4;
    localparam int REF_PERIOD = 12;

    logic        ref_clk = 1'b0;
    logic        vco_clk = 1'b0;
    logic        ref_rst_n = 1'b0;
    logic        vco_rst_n = 1'b0;
    logic [13:0] ref_ratio = 14'd10;
    logic        pre_small = 1'b1;
    logic [6:0]  swallow_cnt = 7'd1;
    logic [10:0] main_cnt = 11'd3;
    logic        fr, fp, mod_hi, cfg_err;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string ref_tag = "R1";
    string fb_tag  = "R3";

    // reference model state
    int r_started = 0, r_pos = 0, r_len = 0;
    int f_started = 0, f_pos = 0, f_len = 0, f_modlen = 0;
    bit f_err = 1'b0;

    always #(VCO_PERIOD/2) vco_clk = ~vco_clk;
    always #(REF_PERIOD/2) ref_clk = ~ref_clk;

    dc_divider_chain dut (
        .ref_clk     (ref_clk),
        .ref_rst_n   (ref_rst_n),
        .ref_ratio   (ref_ratio),
        .vco_clk     (vco_clk),
        .vco_rst_n   (vco_rst_n),
        .pre_small   (pre_small),
        .swallow_cnt (swallow_cnt),
        .main_cnt    (main_cnt),
        .fr          (fr),
        .fp          (fp),
        .mod_hi      (mod_hi),
        .cfg_err     (cfg_err)
    );

    task automatic fb_capture();
        int p, n, a;
        p = pre_small ? 32 : 64;
        n = (main_cnt == 0) ? 1 : int'(main_cnt);
        a = int'(swallow_cnt);
        f_err = (a > n);
        if (a > n) a = n;
        f_len    = n * p + a;
        f_modlen = a * (p + 1);
    endtask

    always @(posedge ref_clk) begin
        if (!ref_rst_n) r_started = 0;
        else if (r_started == 0 || r_pos == r_len) begin
            r_started = 1;
            r_len = (ref_ratio < 14'd8) ? 8 : int'(ref_ratio);
            r_pos = 1;
        end else r_pos++;
    end

    always @(posedge vco_clk) begin
        if (!vco_rst_n) f_started = 0;
        else if (f_started == 0 || f_pos == f_len) begin
            f_started = 1;
            fb_capture();
            f_pos = 1;
        end else f_pos++;
    end

    task automatic check_bit(string tag, string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
        end
    endtask

    always @(negedge ref_clk) begin
        if (!done) begin
            if (!ref_rst_n) check_bit("R9", "fr", fr, 1'b0);
            else check_bit(ref_tag, "fr", fr, (r_started != 0) && (r_pos == r_len));
        end
    end

    always @(negedge vco_clk) begin
        if (!done) begin
            if (!vco_rst_n || f_started == 0) begin
                check_bit("R9", "fp", fp, 1'b0);
                check_bit("R9", "mod_hi", mod_hi, 1'b0);
                check_bit("R9", "cfg_err", cfg_err, 1'b0);
            end else begin
                check_bit(fb_tag, "fp", fp, f_pos == f_len);
                check_bit("R4", "mod_hi", mod_hi, f_pos <= f_modlen);
                check_bit("R7", "cfg_err", cfg_err, f_err);
            end
        end
    end

    task automatic wait_vco(int n);
        repeat (n) @(posedge vco_clk);
        #1;
    endtask

    initial begin
        wait_vco(6);
        ref_rst_n = 1'b1;
        vco_rst_n = 1'b1;
        // R1 R3 R5: 32/33, N=3, A=1 -> 97; R=10
        wait_vco(400);
        // R2 R5: 64/65, N=2, A=1 -> 129; R=3 runs as 8
        ref_tag = "R2"; fb_tag = "R5";
        pre_small = 1'b0; main_cnt = 11'd2; swallow_cnt = 7'd1; ref_ratio = 14'd3;
        wait_vco(450);
        // R6 R4: mid-period change, A=N=2 -> 66; R=20
        ref_tag = "R6"; fb_tag = "R6";
        pre_small = 1'b1; main_cnt = 11'd2; swallow_cnt = 7'd2; ref_ratio = 14'd20;
        wait_vco(300);
        // R4: no swallow, N=3 -> 96
        fb_tag = "R4"; ref_tag = "R1";
        swallow_cnt = 7'd0; main_cnt = 11'd3;
        wait_vco(300);
        // R7: A=5 > N=2 -> clamp, 66, error flag
        fb_tag = "R7";
        swallow_cnt = 7'd5; main_cnt = 11'd2;
        wait_vco(300);
        // R8: N=0 runs as 1 -> 32, then A=1 -> 33
        fb_tag = "R8";
        swallow_cnt = 7'd0; main_cnt = 11'd0;
        wait_vco(200);
        swallow_cnt = 7'd1;
        wait_vco(200);
        // R9: reset mid-run, then restart
        fb_tag = "R9";
        vco_rst_n = 1'b0;
        wait_vco(20);
        vco_rst_n = 1'b1;
        fb_tag = "R3";
        swallow_cnt = 7'd3; main_cnt = 11'd4;
        wait_vco(400);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(VCO_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule